// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives the sequencing side of a sample-and-hold ADC front end with up to four sample channels. On each conversion-done strobe it advances its state. It decides which sample channels take part in a conversion, chooses between two input multiplexer settings, and steps the CH0 positive input through a scan mask. It also produces the write address for each result in a result buffer, which can be split into two halves.

A conversion counter divides the done strobes. Normally it raises a one-clock interrupt pulse after a programmed number of conversions. In DMA mode it instead raises a one-clock DMA address-increment pulse, and the programmed range is twice as large. In split-buffer mode every interrupt event moves filling to the other buffer half, and a status bit reports which half is being filled.

Deasserting `enable` or pulsing `cfg_wr` returns all sequencing state to its start point. Software pulses `cfg_wr` whenever it changes the control fields.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, and in the cycle after `cfg_wr` is pulsed, the state is at its start point: `irq_pulse`=0, `dma_inc`=0, `mux_b`=0, `buf_half`=0 and `wr_addr`=0. The conversion count also restarts, so the next full period is counted from the first strobe.
- R2: With `dma_mode`=0, `irq_pulse` goes high for one clock after every (rate[3:0]+1)th strobe. It is high in the same cycle as the strobe that completes the count, so the period runs from 1 to 16. rate[4] has no effect in this mode.
- R3: With `dma_mode`=1, `dma_inc` goes high for one clock after every (rate+1)th strobe, in the same cycle as that strobe, so the period runs from 1 to 32. `irq_pulse` stays 0 in this mode.
- R4: `ch_en` bit i enables sample channel CHi. A `chan_sel` of 00 gives 0001, 01 gives 0011, and 10 or 11 gives 1111.
- R5: With `res12`=1, `ch_en` is 0001 whatever `chan_sel` holds, and each conversion produces one result.
- R6: With `alt_en`=1, `mux_b` is 0 for the first sample after a clear and toggles after each strobe, so 0 selects MUXA and 1 selects MUXB. With `alt_en`=0, `mux_b` stays 0.
- R7: With `bufm_en`=1, filling starts in the first half (`buf_half`=0) and moves to the other half after each period event. With `bufm_en`=0, `buf_half` stays 0.
- R8: Let L be the number of enabled channels and P the event period. During the k-th strobe of a period (k counted from 0), `wr_addr` equals k*L, plus P*L when `buf_half`=1. With `bufm_en`=0 the address therefore returns to 0 after each event.
- R9: With `scan_en`=1 and a nonzero `scan_mask`, `ch0_sel` is the lowest set mask bit at or above the scan position, wrapping past bit 15. Only a strobe taken while `mux_b`=0 moves the position to just past the selected bit. With `scan_en`=0, or with an all-zero mask, `ch0_sel` is 0.
- R10: While `enable`=0, strobes have no effect. No pulse occurs, `wr_addr`, `mux_b` and `buf_half` stay 0, and counting restarts once `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Controller on; 0 clears all sequencing state |
| cfg_wr | input | 1 | Control-field write strobe; clears sequencing state |
| rate | input | RATE_W | Event period minus one |
| chan_sel | input | 2 | Sample-channel count select |
| res12 | input | 1 | 12-bit resolution mode, CH0 only |
| alt_en | input | 1 | Alternate MUXA/MUXB per sample |
| bufm_en | input | 1 | Split-buffer fill mode |
| scan_en | input | 1 | Step CH0 positive input through the scan mask |
| scan_mask | input | SCAN_W | Inputs taking part in the scan |
| dma_mode | input | 1 | Events advance the DMA address instead of interrupting |
| conv_done | input | 1 | One strobe per completed sample/conversion |
| ch_en | output | 4 | Sample channel enables, bit i = CHi |
| mux_b | output | 1 | 1 = MUXB input selects, 0 = MUXA |
| ch0_sel | output | log2(SCAN_W) | CH0 positive input index |
| irq_pulse | output | 1 | One-clock interrupt event |
| dma_inc | output | 1 | One-clock DMA address-increment event |
| wr_addr | output | RATE_W+3 | Buffer address of the current first result |
| buf_half | output | 1 | 1 while the second buffer half is filled |

## Verification
The bench builds the block with its defaults, RATE_W=5 and SCAN_W=16. These values reach the longest DMA period of 32, where the non-DMA period must stop at 16 with the same rate value, and the full 16-input scan wrap from bit 15 back to bit 2. Split-buffer addressing is driven with one, two and four results per conversion. This makes the second-half base differ from the period count, so an address that ignores the channel count or the half offset gives a different value.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC conversion sequence controller.
// Assumes four sample-and-hold channels in the front end.
package adc_seq_pkg;
    localparam int NUM_SH = 4;

    typedef enum logic [1:0] {
        SEL_CH0   = 2'b00,
        SEL_CH01  = 2'b01,
        SEL_ALL_A = 2'b10,
        SEL_ALL_B = 2'b11
    } chsel_e;
endpackage

// File: rtl/adc_seq_counter.sv
// Conversion counter: divides conversion strobes and raises the period event.
// Assumes: the period changes only together with clr; pulses are combinational
// on done so they line up with the completing strobe.
module adc_seq_counter #(
    parameter int RATE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              done,
    input  logic [RATE_W-1:0] last,
    input  logic              dma_mode,
    output logic              evt,
    output logic              irq,
    output logic              dma_inc
);
    logic [RATE_W-1:0] cnt;

    // Period event when the completing strobe arrives.
    assign evt     = done && (cnt == last);
    assign irq     = evt && !dma_mode;
    assign dma_inc = evt && dma_mode;

    // Count strobes, restart on event or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (evt)      cnt <= '0;
        else if (done)     cnt <= cnt + 1'b1;
    end

    a_r2_pulse_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_inc) |-> done);
    a_r3_no_irq_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |-> !irq);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (cnt <= last));
    a_r1_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
endmodule

// File: rtl/adc_seq_muxscan.sv
// MUXA/MUXB alternation and CH0 scan stepping.
// Assumes SCAN_W is a power of two so position arithmetic wraps naturally.
module adc_seq_muxscan #(
    parameter int SCAN_W = 16,
    localparam int SIDX_W = $clog2(SCAN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              done,
    input  logic              alt_en,
    input  logic              scan_en,
    input  logic [SCAN_W-1:0] mask,
    output logic              mux_b,
    output logic [SIDX_W-1:0] ch0_sel
);
    logic [SIDX_W-1:0] start;
    logic [SIDX_W-1:0] hit;
    logic [SIDX_W-1:0] pos;
    logic              found;

    // Search for the first set mask bit at or above the scan position.
    always_comb begin
        hit   = '0;
        found = 1'b0;
        pos   = '0;
        for (int k = 0; k < SCAN_W; k++) begin
            pos = start + SIDX_W'(k);
            if (!found && mask[pos]) begin
                found = 1'b1;
                hit   = pos;
            end
        end
    end

    assign ch0_sel = (scan_en && found) ? hit : '0;

    // Toggle the mux phase per strobe in alternating mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        mux_b <= 1'b0;
        else if (done && alt_en)  mux_b <= ~mux_b;
    end

    // Advance the scan position after a MUXA strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                             start <= '0;
        else if (done && scan_en && !mux_b && found)   start <= hit + 1'b1;
    end

    a_r6_alt_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && done && alt_en) |=> (mux_b != $past(mux_b)));
    a_r6_muxa_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !alt_en) |-> !mux_b);
    a_r9_sel_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && (|mask)) |-> mask[ch0_sel]);
endmodule

// File: rtl/adc_seq_bufaddr.sv
// Result buffer pointer and half tracking.
// Assumes half_size and lanes change only together with clr.
module adc_seq_bufaddr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              done,
    input  logic              evt,
    input  logic              bufm,
    input  logic [2:0]        lanes,
    input  logic [ADDR_W-1:0] half_size,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              buf_half
);
    logic [ADDR_W-1:0] ptr;

    assign wr_addr = buf_half ? (ptr + half_size) : ptr;

    // Step the pointer by the results per conversion, restart per event.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ptr <= '0;
        else if (evt)      ptr <= '0;
        else if (done)     ptr <= ptr + ADDR_W'(lanes);
    end

    // Swap halves on each event in split-buffer mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     buf_half <= 1'b0;
        else if (evt && bufm)  buf_half <= ~buf_half;
    end

    a_r8_ptr_in_half: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |-> (ptr < half_size));
    a_r7_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(evt && bufm)) |=> $stable(buf_half));
    a_r7_single_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !bufm) |-> !buf_half);
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion sequence controller top: decodes the control fields and
// ties counter, mux/scan and buffer addressing together.
// Assumes software pulses cfg_wr whenever it changes a control field.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RATE_W = 5,
    parameter int SCAN_W = 16,
    localparam int SIDX_W = $clog2(SCAN_W),
    localparam int ADDR_W = RATE_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_wr,
    input  logic [RATE_W-1:0]  rate,
    input  logic [1:0]         chan_sel,
    input  logic               res12,
    input  logic               alt_en,
    input  logic               bufm_en,
    input  logic               scan_en,
    input  logic [SCAN_W-1:0]  scan_mask,
    input  logic               dma_mode,
    input  logic               conv_done,
    output logic [NUM_SH-1:0]  ch_en,
    output logic               mux_b,
    output logic [SIDX_W-1:0]  ch0_sel,
    output logic               irq_pulse,
    output logic               dma_inc,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic               buf_half
);
    logic              clr, done, evt;
    logic [RATE_W-1:0] last;
    logic [1:0]        nsh;
    logic [2:0]        lanes;
    logic [ADDR_W-1:0] half_size;

    assign clr  = !enable || cfg_wr;
    assign done = conv_done && enable && !cfg_wr;

    // Period minus one: top rate bit only counts in DMA mode.
    assign last = dma_mode ? rate : {1'b0, rate[RATE_W-2:0]};

    // Results per conversion as a power-of-two shift.
    always_comb begin
        if (res12) nsh = 2'd0;
        else begin
            case (chsel_e'(chan_sel))
                SEL_CH0:  nsh = 2'd0;
                SEL_CH01: nsh = 2'd1;
                default:  nsh = 2'd2;
            endcase
        end
    end

    assign lanes     = 3'd1 << nsh;
    assign half_size = (ADDR_W'(last) + ADDR_W'(1)) << nsh;

    for (genvar g = 0; g < NUM_SH; g++) begin : g_lane
        assign ch_en[g] = (3'(g) < lanes);
    end

    adc_seq_counter #(.RATE_W(RATE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .last(last),
        .dma_mode(dma_mode), .evt(evt), .irq(irq_pulse), .dma_inc(dma_inc)
    );

    adc_seq_muxscan #(.SCAN_W(SCAN_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .alt_en(alt_en),
        .scan_en(scan_en), .mask(scan_mask), .mux_b(mux_b), .ch0_sel(ch0_sel)
    );

    adc_seq_bufaddr #(.ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .evt(evt),
        .bufm(bufm_en), .lanes(lanes), .half_size(half_size),
        .wr_addr(wr_addr), .buf_half(buf_half)
    );

    a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        res12 |-> (ch_en == 4'b0001));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!irq_pulse && !dma_inc));
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, enable, cfg_wr, res12, alt_en, bufm_en, scan_en, dma_mode, conv_done;
    logic [4:0]  rate;
    logic [1:0]  chan_sel;
    logic [15:0] scan_mask;
    logic [3:0]  ch_en;
    logic        mux_b, irq_pulse, dma_inc, buf_half;
    logic [3:0]  ch0_sel;
    logic [7:0]  wr_addr;

    int n_chk = 0;
    int n_bad = 0;
    int s_irq, s_dma, s_addr, s_mux, s_sel, s_half, p_irq, p_dma;

    always #2.5 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr), .rate(rate),
        .chan_sel(chan_sel), .res12(res12), .alt_en(alt_en), .bufm_en(bufm_en),
        .scan_en(scan_en), .scan_mask(scan_mask), .dma_mode(dma_mode),
        .conv_done(conv_done), .ch_en(ch_en), .mux_b(mux_b), .ch0_sel(ch0_sel),
        .irq_pulse(irq_pulse), .dma_inc(dma_inc), .wr_addr(wr_addr), .buf_half(buf_half)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [4:0] r, input logic [1:0] cs, input logic r12,
                           input logic alt, input logic bm, input logic sc,
                           input logic dm, input logic [15:0] msk);
        @(negedge clk);
        rate = r; chan_sel = cs; res12 = r12; alt_en = alt; bufm_en = bm;
        scan_en = sc; dma_mode = dm; scan_mask = msk; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    // One conversion strobe; capture outputs during and after it.
    task automatic strobe();
        @(negedge clk);
        conv_done = 1'b1;
        #1;
        s_irq = irq_pulse; s_dma = dma_inc; s_addr = wr_addr;
        s_mux = mux_b; s_sel = ch0_sel; s_half = buf_half;
        @(negedge clk);
        conv_done = 1'b0;
        #1;
        p_irq = irq_pulse; p_dma = dma_inc;
    endtask

    task automatic t_reset();
        chk("R1 irq at reset", irq_pulse, 0);
        chk("R1 dma at reset", dma_inc, 0);
        chk("R1 mux at reset", mux_b, 0);
        chk("R1 half at reset", buf_half, 0);
        chk("R1 addr at reset", wr_addr, 0);
        chk("R4 ch_en default", ch_en, 1);
    endtask

    task automatic t_chan();
        for (int cs = 0; cs < 4; cs++) begin
            for (int r12 = 0; r12 < 2; r12++) begin
                set_cfg(5'd0, 2'(cs), 1'(r12), 0, 0, 0, 0, 16'h0);
                if (r12 == 1) chk("R5 ch_en in 12-bit", ch_en, 1);
                else chk("R4 ch_en decode", ch_en, (cs == 0) ? 1 : (cs == 1) ? 3 : 15);
            end
        end
    endtask

    task automatic t_irq_rate();
        set_cfg(5'b10010, 0, 0, 0, 0, 0, 0, 16'h0);
        for (int k = 0; k < 9; k++) begin
            strobe();
            chk("R2 irq period 3, rate[4] ignored", s_irq, (k % 3 == 2) ? 1 : 0);
            chk("R3 no dma pulse when off", s_dma, 0);
            chk("R2 irq one clock wide", p_irq, 0);
        end
        set_cfg(5'd0, 0, 0, 0, 0, 0, 0, 16'h0);
        for (int k = 0; k < 3; k++) begin
            strobe();
            chk("R2 irq every strobe", s_irq, 1);
        end
        set_cfg(5'd31, 0, 0, 0, 0, 0, 0, 16'h0);
        for (int k = 0; k < 32; k++) begin
            strobe();
            chk("R2 irq period 16 max", s_irq, (k % 16 == 15) ? 1 : 0);
        end
    endtask

    task automatic t_dma_rate();
        set_cfg(5'd19, 0, 0, 0, 0, 0, 1, 16'h0);
        for (int k = 0; k < 40; k++) begin
            strobe();
            chk("R3 dma period 20", s_dma, (k % 20 == 19) ? 1 : 0);
            chk("R3 irq silent in dma", s_irq, 0);
            chk("R3 dma one clock wide", p_dma, 0);
        end
        set_cfg(5'd31, 0, 0, 0, 0, 0, 1, 16'h0);
        for (int k = 0; k < 64; k++) begin
            strobe();
            chk("R3 dma period 32", s_dma, (k % 32 == 31) ? 1 : 0);
        end
    endtask

    task automatic t_alt();
        set_cfg(5'd3, 0, 0, 1, 0, 0, 0, 16'h0);
        chk("R1 mux cleared by cfg write", mux_b, 0);
        for (int k = 0; k < 6; k++) begin
            strobe();
            chk("R6 mux alternates", s_mux, k % 2);
        end
        set_cfg(5'd3, 0, 0, 0, 0, 0, 0, 16'h0);
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R6 mux fixed on A", s_mux, 0);
        end
    endtask

    task automatic t_buf();
        int a2[6] = '{0, 2, 4, 6, 0, 2};
        int h2[6] = '{0, 0, 1, 1, 0, 0};
        int a4[7] = '{0, 4, 8, 12, 16, 20, 0};
        int h4[7] = '{0, 0, 0, 1, 1, 1, 0};
        set_cfg(5'd1, 2'b01, 0, 0, 1, 0, 0, 16'h0);
        for (int k = 0; k < 6; k++) begin
            strobe();
            chk("R8 addr two lanes split", s_addr, a2[k]);
            chk("R7 half two lanes", s_half, h2[k]);
        end
        set_cfg(5'd1, 2'b01, 0, 0, 0, 0, 0, 16'h0);
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R8 addr restarts without split", s_addr, (k % 2) * 2);
            chk("R7 half stays 0", s_half, 0);
        end
        set_cfg(5'd2, 2'b10, 0, 0, 1, 0, 0, 16'h0);
        for (int k = 0; k < 7; k++) begin
            strobe();
            chk("R8 addr four lanes split", s_addr, a4[k]);
            chk("R7 half four lanes", s_half, h4[k]);
        end
        set_cfg(5'd1, 2'b11, 1, 0, 1, 0, 0, 16'h0);
        for (int k = 0; k < 5; k++) begin
            strobe();
            chk("R5 one result per conversion", s_addr, k % 4);
        end
    endtask

    task automatic t_scan();
        int sa[5] = '{2, 5, 15, 2, 5};
        int sb[6] = '{2, 5, 5, 15, 15, 2};
        set_cfg(5'd0, 0, 0, 0, 0, 1, 0, 16'h8024);
        for (int k = 0; k < 5; k++) begin
            strobe();
            chk("R9 scan ascending with wrap", s_sel, sa[k]);
        end
        set_cfg(5'd0, 0, 0, 1, 0, 1, 0, 16'h8024);
        for (int k = 0; k < 6; k++) begin
            strobe();
            chk("R9 scan advances on MUXA only", s_sel, sb[k]);
        end
        set_cfg(5'd0, 0, 0, 0, 0, 0, 0, 16'h8024);
        for (int k = 0; k < 2; k++) begin
            strobe();
            chk("R9 scan off keeps input 0", s_sel, 0);
        end
        set_cfg(5'd0, 0, 0, 0, 0, 1, 0, 16'h0);
        strobe();
        chk("R9 empty mask gives 0", s_sel, 0);
    endtask

    task automatic t_clear();
        set_cfg(5'd3, 0, 0, 1, 1, 0, 0, 16'h0);
        for (int k = 0; k < 5; k++) strobe();
        chk("R8 addr in second half", s_addr, 4);
        set_cfg(5'd3, 0, 0, 1, 1, 0, 0, 16'h0);
        chk("R1 mux after cfg write", mux_b, 0);
        chk("R1 addr after cfg write", wr_addr, 0);
        chk("R1 half after cfg write", buf_half, 0);
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R1 count restarts after cfg write", s_irq, (k == 3) ? 1 : 0);
        end
        @(negedge clk);
        enable = 1'b0;
        for (int k = 0; k < 5; k++) begin
            strobe();
            chk("R10 no irq while disabled", s_irq, 0);
            chk("R10 addr held while disabled", s_addr, 0);
            chk("R10 mux held while disabled", s_mux, 0);
            chk("R10 half cleared while disabled", s_half, 0);
        end
        @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R10 count restarts on enable", s_irq, (k == 3) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; cfg_wr = 1'b0; res12 = 1'b0; alt_en = 1'b0;
        bufm_en = 1'b0; scan_en = 1'b0; dma_mode = 1'b0; conv_done = 1'b0;
        rate = 5'd0; chan_sel = 2'b00; scan_mask = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_chan();
        t_irq_rate();
        t_dma_rate();
        t_alt();
        t_buf();
        t_scan();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule